// File: doc/BRIEF.md
# Timer Interrupt Vector Priority Encoder

This block gathers the interrupt flags of a timer and turns them into two interrupt requests. Channel 0 owns a dedicated request line. Its flag is cleared when the interrupt controller acknowledges that request, and it outranks every other timer source. The other capture/compare channels (four by default) and the counter overflow flag share a second request. A fixed priority arbitrates among them, and a vector value names the winner so that a handler can jump straight to the right code.

Each flag is set by a one-cycle pulse from the flag generation logic. A flag takes part only while its own enable is high. Both requests are further qualified by a global enable. The vector itself ignores the global enable, so turning interrupts off globally leaves the reported value unchanged. A read or a write strobe on the vector port clears exactly the source the vector names in that cycle. If other sources are still pending, the next one appears at once and the shared request stays high.

Top module: `tmr_irq_vector`

## Requirements
- R1: While `rst` is high at a rising clock edge, every flag is cleared, even if a set pulse arrives in that cycle. After such an edge `vec_value` is 0 and both requests are 0.
- R2: A set pulse sampled at a rising edge makes its flag pending from that edge on. The effect shows on `vec_value` and the request outputs in the same cycle that follows the edge.
- R3: `irq_ch0` is high exactly when the channel 0 flag is set and both `ch0_en` and `gie` are high. A `ch0_ack` sampled at an edge clears that flag. Channel 0 never appears in `vec_value`.
- R4: The shared sources have this fixed priority: channel 1 highest, then channels 2, 3 and 4, with overflow lowest. `vec_value` encodes the winner as 0 for none, 2 for channel 1, 4 for channel 2, 6 for channel 3, 8 for channel 4 and 10 for overflow. In general, shared channel k codes as 2k and overflow codes as 2*(NUM_CH+1).
- R5: A flag whose own enable is low neither appears in `vec_value` nor drives a request. It still stays pending, and it shows up once its enable is raised.
- R6: When `gie` is low, both requests are low. `vec_value` does not change because of `gie`.
- R7: A cycle with `vec_rd` or `vec_wr` high clears only the flag that `vec_value` names in that cycle. Any remaining enabled flags stay pending, and `irq_shared` stays high in the next cycle.
- R8: A set pulse that lands in the same cycle as a clear of the same flag (a vector access or `ch0_ack`) leaves the flag set.
- R9: A vector access while `vec_value` is 0 clears nothing. This includes disabled flags, which stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable |
| ch0_set | input | 1 | Channel 0 flag set pulse |
| ch0_en | input | 1 | Channel 0 enable |
| ch0_ack | input | 1 | Channel 0 request acknowledge, clears its flag |
| chn_set | input | NUM_CH | Set pulses of shared channels 1..NUM_CH (bit 0 = channel 1) |
| chn_en | input | NUM_CH | Enables of shared channels 1..NUM_CH (bit 0 = channel 1) |
| ovf_set | input | 1 | Overflow flag set pulse |
| ovf_en | input | 1 | Overflow enable |
| vec_rd | input | 1 | Vector read strobe |
| vec_wr | input | 1 | Vector write strobe |
| vec_value | output | VEC_W | Code of the highest-priority pending enabled shared source |
| irq_ch0 | output | 1 | Channel 0 interrupt request |
| irq_shared | output | 1 | Combined request of the shared sources |

## Verification
The assertions check several properties on every cycle: that the vector code is always legal (even and in range), that it never names a disabled source, that a global disable silences both requests, that an acknowledge without a coincident set drops the channel 0 request, and that an access which meets no coincident set moves the vector off the value it reported. The exact priority order, draining a full set of pending flags one access at a time, set-wins collisions, reset overriding a set pulse, and a disabled flag reappearing when it is enabled all depend on stimulus history. Only the scoreboard scenarios, with their reference model, can show those.

// File: rtl/tiv_pkg.sv
package tiv_pkg;

    // Code reported for shared source position pos (0 = channel 1).
    function automatic int unsigned code_of(int unsigned pos);
        return 2 * (pos + 1);
    endfunction

    // Kind of clear that hits a flag bank in a cycle.
    typedef enum logic [1:0] {
        CLR_NONE   = 2'b00,
        CLR_ACK    = 2'b01,
        CLR_ACCESS = 2'b10
    } clr_kind_e;

    // Result of the shared priority search.
    typedef struct packed {
        logic       any;
        logic [7:0] pos;
    } win_t;

endpackage

// File: rtl/tiv_flag_bank.sv
module tiv_flag_bank #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (clr_i[i])
                q <= 1'b0;
        end
        assign flag_o[i] = q;
    end
endmodule

// File: rtl/tiv_prio_enc.sv
module tiv_prio_enc
    import tiv_pkg::*;
#(
    parameter int N     = 5,
    parameter int VEC_W = 4
) (
    input  logic [N-1:0]     pend_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [N-1:0]     hit_o
);
    win_t win;

    always_comb begin
        win = '0;
        // Walk from lowest priority up so the highest priority wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                win.any = 1'b1;
                win.pos = 8'(i);
            end
        end
    end

    always_comb begin
        hit_o = '0;
        vec_o = '0;
        if (win.any) begin
            hit_o[win.pos] = 1'b1;
            vec_o          = VEC_W'(code_of(32'(win.pos)));
        end
    end
endmodule

// File: rtl/tiv_req_gate.sv
module tiv_req_gate #(
    parameter int N = 5
) (
    input  logic         gie_i,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_o,
    output logic         req_o
);
    assign pend_o = flag_i & en_i;
    assign req_o  = gie_i & (|pend_o);
endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector
    import tiv_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int NSRC  = NUM_CH + 1,
    localparam int VEC_W = $clog2(2 * NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gie,
    input  logic              ch0_set,
    input  logic              ch0_en,
    input  logic              ch0_ack,
    input  logic [NUM_CH-1:0] chn_set,
    input  logic [NUM_CH-1:0] chn_en,
    input  logic              ovf_set,
    input  logic              ovf_en,
    input  logic              vec_rd,
    input  logic              vec_wr,
    output logic [VEC_W-1:0]  vec_value,
    output logic              irq_ch0,
    output logic              irq_shared
);
    // Shared source vector: positions 0..NUM_CH-1 are channels, top is overflow.
    logic [NSRC-1:0] sh_set, sh_en, sh_flag, sh_pend, sh_hit, sh_clr;
    logic [0:0]      c0_flag, c0_pend;
    clr_kind_e       sh_kind, c0_kind;

    assign sh_set = {ovf_set, chn_set};
    assign sh_en  = {ovf_en, chn_en};

    assign sh_kind = (vec_rd || vec_wr) ? CLR_ACCESS : CLR_NONE;
    assign c0_kind = ch0_ack ? CLR_ACK : CLR_NONE;
    assign sh_clr  = (sh_kind == CLR_ACCESS) ? sh_hit : '0;

    tiv_flag_bank #(.N(NSRC)) u_sh_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (sh_set),
        .clr_i  (sh_clr),
        .flag_o (sh_flag)
    );

    tiv_req_gate #(.N(NSRC)) u_sh_gate (
        .gie_i  (gie),
        .flag_i (sh_flag),
        .en_i   (sh_en),
        .pend_o (sh_pend),
        .req_o  (irq_shared)
    );

    tiv_prio_enc #(.N(NSRC), .VEC_W(VEC_W)) u_enc (
        .pend_i (sh_pend),
        .vec_o  (vec_value),
        .hit_o  (sh_hit)
    );

    tiv_flag_bank #(.N(1)) u_c0_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ch0_set),
        .clr_i  (c0_kind == CLR_ACK),
        .flag_o (c0_flag)
    );

    tiv_req_gate #(.N(1)) u_c0_gate (
        .gie_i  (gie),
        .flag_i (c0_flag),
        .en_i   (ch0_en),
        .pend_o (c0_pend),
        .req_o  (irq_ch0)
    );
endmodule

// File: rtl/tiv_checker.sv
module tiv_checker #(
    parameter int NUM_CH = 4,
    localparam int NSRC  = NUM_CH + 1,
    localparam int VEC_W = $clog2(2 * NSRC + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              gie,
    input logic              ch0_set,
    input logic              ch0_ack,
    input logic [NUM_CH-1:0] chn_set,
    input logic [NUM_CH-1:0] chn_en,
    input logic              ovf_set,
    input logic              ovf_en,
    input logic              vec_rd,
    input logic              vec_wr,
    input logic [VEC_W-1:0]  vec_value,
    input logic              irq_ch0,
    input logic              irq_shared
);
    logic [NSRC-1:0] all_set, all_en;
    logic            src_set, src_en;
    int              pos;

    assign all_set = {ovf_set, chn_set};
    assign all_en  = {ovf_en, chn_en};

    always_comb begin
        pos     = int'(vec_value) / 2 - 1;
        src_set = 1'b0;
        src_en  = 1'b0;
        if (pos >= 0 && pos < NSRC) begin
            src_set = all_set[pos];
            src_en  = all_en[pos];
        end
    end

    // R4: code is even and within the legal range
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        (vec_value[0] == 1'b0) && (int'(vec_value) <= 2 * NSRC));

    // R5: the reported source always has its own enable high
    a_r5_enabled_only: assert property (@(posedge clk) disable iff (rst)
        (vec_value != '0) |-> src_en);

    // R6: global disable silences both requests
    a_r6_gie_mutes: assert property (@(posedge clk) disable iff (rst)
        !gie |-> (!irq_shared && !irq_ch0));

    // R3: acknowledge without a coincident set drops the channel 0 request
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ch0_ack && !ch0_set) |=> !irq_ch0);

    // R7: an access clears the reported source, so the vector moves off it
    a_r7_access_moves: assert property (@(posedge clk) disable iff (rst)
        ((vec_rd || vec_wr) && vec_value != '0 && !src_set)
        |=> (vec_value != $past(vec_value)));
endmodule

bind tmr_irq_vector tiv_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gie        (gie),
    .ch0_set    (ch0_set),
    .ch0_ack    (ch0_ack),
    .chn_set    (chn_set),
    .chn_en     (chn_en),
    .ovf_set    (ovf_set),
    .ovf_en     (ovf_en),
    .vec_rd     (vec_rd),
    .vec_wr     (vec_wr),
    .vec_value  (vec_value),
    .irq_ch0    (irq_ch0),
    .irq_shared (irq_shared)
);

// File: tb/tmr_irq_vector_tb.sv
module tmr_irq_vector_tb;
    localparam int NUM_CH = 4;
    localparam int NSRC   = NUM_CH + 1;
    localparam int VW     = $clog2(2 * NSRC + 1);

    logic              clk = 1'b0;
    logic              rst, gie, ch0_set, ch0_en, ch0_ack, ovf_set, ovf_en, vec_rd, vec_wr;
    logic [NUM_CH-1:0] chn_set, chn_en;
    logic [VW-1:0]     vec_value;
    logic              irq_ch0, irq_shared;

    always #4 clk = ~clk;

    tmr_irq_vector #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .gie(gie),
        .ch0_set(ch0_set), .ch0_en(ch0_en), .ch0_ack(ch0_ack),
        .chn_set(chn_set), .chn_en(chn_en),
        .ovf_set(ovf_set), .ovf_en(ovf_en),
        .vec_rd(vec_rd), .vec_wr(vec_wr),
        .vec_value(vec_value), .irq_ch0(irq_ch0), .irq_shared(irq_shared)
    );

    typedef struct {
        string tag;
        int    vec;
        bit    sh;
        bit    c0;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;

    // Reference state, built from the requirements.
    bit                m_f [NSRC];
    bit                m_c0;
    logic [NUM_CH-1:0] d_chen = '1;
    bit                d_oven = 1'b1, d_c0en = 1'b1, d_gie = 1'b1;

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_vec();
        for (int i = 0; i < NSRC; i++) begin
            bit en;
            en = (i < NUM_CH) ? d_chen[i] : d_oven;
            if (m_f[i] && en) return 2 * (i + 1);
        end
        return 0;
    endfunction

    task automatic step(string tag, bit s0, bit a0, logic [NUM_CH-1:0] cs, bit os, bit rd, bit wr);
        int   pre, nv;
        exp_t e;
        @(negedge clk);
        ch0_set = s0; ch0_ack = a0; chn_set = cs; ovf_set = os;
        vec_rd = rd; vec_wr = wr;
        chn_en = d_chen; ovf_en = d_oven; ch0_en = d_c0en; gie = d_gie;
        pre = model_vec();
        if ((rd || wr) && pre != 0) m_f[pre / 2 - 1] = 1'b0;
        for (int i = 0; i < NUM_CH; i++) if (cs[i]) m_f[i] = 1'b1;
        if (os) m_f[NUM_CH] = 1'b1;
        if (a0) m_c0 = 1'b0;
        if (s0) m_c0 = 1'b1;
        nv    = model_vec();
        e.tag = tag;
        e.vec = nv;
        e.sh  = d_gie && (nv != 0);
        e.c0  = m_c0 && d_c0en && d_gie;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, '0, 0, 0, 0);
    endtask

    // Monitor: compares each expected item after the edge it belongs to.
    always @(posedge clk) begin
        #3;
        if (q.size() > 0) begin
            cur = q.pop_front();
            chk(cur.tag, "vec_value", int'(vec_value), cur.vec);
            chk(cur.tag, "irq_shared", int'(irq_shared), int'(cur.sh));
            chk(cur.tag, "irq_ch0", int'(irq_ch0), int'(cur.c0));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; gie = 1'b1; ch0_set = 1'b1; ch0_en = 1'b1; ch0_ack = 1'b0;
        chn_set = '1; chn_en = '1; ovf_set = 1'b1; ovf_en = 1'b1;
        vec_rd = 1'b0; vec_wr = 1'b0;
        for (int i = 0; i < NSRC; i++) m_f[i] = 1'b0;
        m_c0 = 1'b0;
        repeat (3) @(negedge clk);
        // R1: set pulses held during reset have no effect
        chk("R1", "vec_value", int'(vec_value), 0);
        chk("R1", "irq_shared", int'(irq_shared), 0);
        chk("R1", "irq_ch0", int'(irq_ch0), 0);
        rst = 1'b0; ch0_set = 1'b0; chn_set = '0; ovf_set = 1'b0;
        idle("R1 idle after reset");

        // R2: single set appears after one edge
        step("R2 set ch3", 0, 0, 4'b0100, 0, 0, 0);
        // R4: ch1 outranks ch3 and overflow
        step("R4 ch1 over ch3/ovf", 0, 0, 4'b0001, 1, 0, 0);
        // R7: read clears ch1 only, request stays
        step("R7 read clears ch1", 0, 0, '0, 0, 1, 0);
        step("R7 write clears ch3", 0, 0, '0, 0, 0, 1);
        // R6: global disable keeps vector
        d_gie = 1'b0;
        idle("R6 gie low vec held");
        d_gie = 1'b1;
        // R8: set coincident with access on overflow
        step("R8 ovf set during clear", 0, 0, '0, 1, 1, 0);
        step("R7 clear ovf", 0, 0, '0, 0, 1, 0);
        // R9: access with nothing pending
        step("R9 empty access", 0, 0, '0, 0, 0, 1);
        // R5: disabled ch2 stays hidden, survives an access, appears on enable
        d_chen = 4'b1101;
        step("R5 set disabled ch2", 0, 0, 4'b0010, 0, 0, 0);
        step("R9 access with disabled flag", 0, 0, '0, 0, 1, 0);
        d_chen = 4'b1111;
        idle("R5 ch2 enabled");
        step("R7 clear ch2", 0, 0, '0, 0, 1, 0);

        // R3: channel 0 path
        step("R3 set ch0", 1, 0, '0, 0, 0, 0);
        idle("R3 ch0 held");
        step("R3 ack ch0", 0, 1, '0, 0, 0, 0);
        step("R3 set ch0 again", 1, 0, '0, 0, 0, 0);
        step("R8 ch0 set during ack", 1, 1, '0, 0, 0, 0);
        d_c0en = 1'b0;
        idle("R3 ch0 disabled");
        d_c0en = 1'b1;
        idle("R3 ch0 reenabled");
        d_gie = 1'b0;
        idle("R6 gie low ch0");
        d_gie = 1'b1;
        step("R3 ack ch0 final", 0, 1, '0, 0, 0, 0);

        // R4: every combination of shared flags, drained one access at a time
        for (int p = 1; p < 32; p++) begin
            logic [4:0] pat;
            pat = 5'(p);
            step("R4 sweep set", 0, 0, pat[3:0], pat[4], 0, 0);
            for (int k = 0; k < NSRC + 1; k++)
                step("R7 sweep drain", 0, 0, '0, 0, k[0], !k[0]);
        end

        repeat (3) idle("end");
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule